// File: doc/BRIEF.md
# Flash Program/Erase Mode Control Register

This block is an 8-bit control register that a processor uses to steer an on-chip flash array into program, erase, program-verify or erase-verify operation. It holds the software-controlled mode bits and a read-only view of the external write-enable pin. Its write path has interlocks in stages, so a bit can change only once the bits it depends on are already set. The block decodes the stored bits into four mode outputs for the flash sequencer.

The register is accessed through a plain single-cycle bus. An address-decoded write strobe loads `wr_data` on the rising clock edge. `rd_data` is combinational. There is no stream interface, so the block applies no back-pressure and every strobe completes in its own cycle. Software enters program mode in three writes: it sets the software enable bit, then the program setup bit, then the program bit. Erase mode uses the same three steps with the erase setup and erase bits.

Top module: `flash_mode_ctl`

## Requirements
- R1: While `flash_en` is 1, `rd_data` reads as {pin mirror, software enable, erase setup, program setup, erase-verify, program-verify, erase, program}, from bit 7 down to bit 0. Bit 7 equals `wp_pin` and ignores written data.
- R2: A low `rst_n`, or a clock edge with `hw_standby` or `sw_standby` high, clears bits 6..0. The register then reads 0x80 with the pin high and 0x00 with the pin low.
- R3: While `flash_en` is 0, `rd_data` is 0x00 and write strobes leave the stored bits unchanged.
- R4: The software enable bit (bit 6) takes written data only while `wp_pin` is 1.
- R5: Bits 5..2 take written data only when the software enable bit already held 1 before the write.
- R6: The erase bit (bit 1) takes written data only when bits 6 and 5 already held 1 before the write. The program bit (bit 0) takes written data only when bits 6 and 4 already held 1 before the write.
- R7: A write that raises bit 5 from 0 to 1 and also raises any of bits 6, 4, 3, 2, 1 or 0 from 0 to 1 is rejected entirely, and the register keeps its value.
- R8: While `wp_pin` is 0, bits 6..0 are held cleared without waiting for a clock edge. They stay cleared after the pin returns high until software writes them again.
- R9: `program_active`, `erase_active`, `pverify_active` and `everify_active` equal bits 0, 1, 2 and 3 respectively, each ANDed with bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_standby | input | 1 | Hardware standby request; clears the register |
| sw_standby | input | 1 | Software standby request; clears the register |
| wp_pin | input | 1 | External flash write-enable pin level |
| flash_en | input | 1 | Strap: on-chip flash present and enabled |
| wr_stb | input | 1 | Address-decoded write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| program_active | output | 1 | Program mode selected |
| erase_active | output | 1 | Erase mode selected |
| pverify_active | output | 1 | Program-verify mode selected |
| everify_active | output | 1 | Erase-verify mode selected |

## Verification
The bench builds the block in its only configuration: an 8-bit register whose bit positions are fixed by the package. Because that state space is small, the bench drives all 256 write values from each of five starting states: cleared, enabled, erase set up, program set up, and both verify bits set. The prerequisite checks and the erase-setup rejection rule for R5 to R7 are therefore tested for every data combination. Separate directed cases cover how the pin level sets the value after reset, the asynchronous clear when the pin drops, the disabled-flash strap and both standby inputs.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

  // Register geometry; bit positions are decoded by software and the sequencer.
  localparam int REG_W    = 8;
  localparam int CTL_W    = REG_W - 1;   // software-held bits 6..0
  localparam int B_PIN    = 7;
  localparam int B_SWEN   = 6;
  localparam int B_ESET   = 5;
  localparam int B_PSET   = 4;
  localparam int B_EVER   = 3;
  localparam int B_PVER   = 2;
  localparam int B_ERS    = 1;
  localparam int B_PRG    = 0;

  typedef logic [CTL_W-1:0] ctl_t;

  // Bits that must not rise together with the erase setup bit.
  localparam ctl_t ESET_CLASH = ctl_t'((1 << B_SWEN) | (1 << B_PSET) | (1 << B_EVER) |
                                       (1 << B_PVER) | (1 << B_ERS)  | (1 << B_PRG));

  // Prerequisite mask for bit idx: every bit of the mask must already be 1.
  function automatic ctl_t prereq_mask(input int idx);
    ctl_t m;
    m = '0;
    if (idx == B_SWEN)      m = '0;
    else if (idx == B_ERS)  m = ctl_t'((1 << B_SWEN) | (1 << B_ESET));
    else if (idx == B_PRG)  m = ctl_t'((1 << B_SWEN) | (1 << B_PSET));
    else                    m = ctl_t'(1 << B_SWEN);
    return m;
  endfunction

  typedef struct packed {
    logic prg;
    logic ers;
    logic pver;
    logic ever;
  } mode_t;

endpackage

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
  import flash_mode_pkg::*;
(
  input  ctl_t cur_q,
  input  ctl_t wdata,
  input  logic wr_ok,
  output ctl_t load_mask,
  output logic reject
);

  ctl_t rising;

  always_comb begin
    rising = wdata & ~cur_q;
    reject = rising[B_ESET] & (|(rising & ESET_CLASH));
  end

  for (genvar i = 0; i < CTL_W; i++) begin : g_bit
    localparam ctl_t PRE = prereq_mask(i);
    assign load_mask[i] = wr_ok & ~reject & ((cur_q & PRE) == PRE);
  end

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_mode_pkg::*;
(
  input  logic clk,
  input  logic hold_n,
  input  logic init,
  input  ctl_t load_mask,
  input  ctl_t wdata,
  output ctl_t ctl_q
);

  for (genvar i = 0; i < CTL_W; i++) begin : g_ff
    always_ff @(posedge clk or negedge hold_n) begin
      if (!hold_n)
        ctl_q[i] <= 1'b0;
      else if (init)
        ctl_q[i] <= 1'b0;
      else if (load_mask[i])
        ctl_q[i] <= wdata[i];
    end
  end

endmodule

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
  import flash_mode_pkg::*;
(
  input  ctl_t  ctl_q,
  output mode_t mode
);

  always_comb begin
    mode.prg  = ctl_q[B_SWEN] & ctl_q[B_PRG];
    mode.ers  = ctl_q[B_SWEN] & ctl_q[B_ERS];
    mode.pver = ctl_q[B_SWEN] & ctl_q[B_PVER];
    mode.ever = ctl_q[B_SWEN] & ctl_q[B_EVER];
  end

endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
  import flash_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_standby,
  input  logic             sw_standby,
  input  logic             wp_pin,
  input  logic             flash_en,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             program_active,
  output logic             erase_active,
  output logic             pverify_active,
  output logic             everify_active
);

  ctl_t  ctl_q;
  ctl_t  load_mask;
  logic  reject;
  logic  hold_n;
  logic  wr_ok;
  mode_t mode;

  // The pin acts as an asynchronous clear alongside power-on reset.
  assign hold_n = rst_n & wp_pin;
  assign wr_ok  = wr_stb & flash_en & wp_pin;

  flash_wr_gate u_gate (
    .cur_q     (ctl_q),
    .wdata     (wr_data[CTL_W-1:0]),
    .wr_ok     (wr_ok),
    .load_mask (load_mask),
    .reject    (reject)
  );

  flash_ctl_reg u_reg (
    .clk       (clk),
    .hold_n    (hold_n),
    .init      (hw_standby | sw_standby),
    .load_mask (load_mask),
    .wdata     (wr_data[CTL_W-1:0]),
    .ctl_q     (ctl_q)
  );

  flash_mode_decode u_dec (
    .ctl_q (ctl_q),
    .mode  (mode)
  );

  assign rd_data        = flash_en ? {wp_pin, ctl_q} : '0;
  assign program_active = mode.prg;
  assign erase_active   = mode.ers;
  assign pverify_active = mode.pver;
  assign everify_active = mode.ever;

endmodule

// File: rtl/flash_mode_ctl_chk.sv
module flash_mode_ctl_chk
  import flash_mode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hw_standby,
  input logic             sw_standby,
  input logic             wp_pin,
  input logic             flash_en,
  input logic             wr_stb,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             program_active,
  input logic             erase_active,
  input logic             pverify_active,
  input logic             everify_active,
  input ctl_t             ctl_q
);

  logic any_init;
  logic esu_clash;
  ctl_t rise;

  always_comb begin
    any_init  = hw_standby | sw_standby;
    rise      = wr_data[CTL_W-1:0] & ~ctl_q;
    esu_clash = rise[B_ESET] & (|(rise & ESET_CLASH));
  end

  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |-> rd_data == '0); // R3

  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_pin |-> ctl_q == '0); // R8

  AST_STANDBY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_init |=> ctl_q == '0); // R2

  AST_NO_WRITE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_en && !any_init) |=> (ctl_q == $past(ctl_q) || ctl_q == '0)); // R3

  AST_SETUP_NEEDS_SWEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[B_SWEN] && !any_init) |=> (ctl_q[B_ESET:B_PVER] == $past(ctl_q[B_ESET:B_PVER]) || ctl_q == '0)); // R5

  AST_ERASE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[B_ERS] && !(ctl_q[B_SWEN] && ctl_q[B_ESET])) |=> !ctl_q[B_ERS]); // R6

  AST_PROGRAM_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[B_PRG] && !(ctl_q[B_SWEN] && ctl_q[B_PSET])) |=> !ctl_q[B_PRG]); // R6

  AST_ESU_CLASH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && esu_clash && !any_init) |=> (ctl_q == $past(ctl_q) || ctl_q == '0)); // R7

  AST_MODES_NEED_SWEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_en && !rd_data[B_SWEN]) |->
      !(program_active || erase_active || pverify_active || everify_active)); // R9

endmodule

bind flash_mode_ctl flash_mode_ctl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hw_standby     (hw_standby),
  .sw_standby     (sw_standby),
  .wp_pin         (wp_pin),
  .flash_en       (flash_en),
  .wr_stb         (wr_stb),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .program_active (program_active),
  .erase_active   (erase_active),
  .pverify_active (pverify_active),
  .everify_active (everify_active),
  .ctl_q          (ctl_q)
);

// File: tb/flash_mode_ctl_tb.sv
module flash_mode_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_standby = 1'b0;
  logic       sw_standby = 1'b0;
  logic       wp_pin = 1'b1;
  logic       flash_en = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       program_active, erase_active, pverify_active, everify_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mode_ctl u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_standby     (hw_standby),
    .sw_standby     (sw_standby),
    .wp_pin         (wp_pin),
    .flash_en       (flash_en),
    .wr_stb         (wr_stb),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .program_active (program_active),
    .erase_active   (erase_active),
    .pverify_active (pverify_active),
    .everify_active (everify_active)
  );

  // Reference next-state from the requirements (bits 6..0).
  function automatic logic [6:0] model_next(input logic [6:0] o, input logic [7:0] d);
    logic [6:0] r, up;
    up = d[6:0] & ~o;
    if (up[5] && ((up & 7'h5F) != 7'h00)) return o;        // R7
    r = o;
    r[6] = d[6];                                            // R4
    if (o[6]) r[5:2] = d[5:2];                              // R5
    if (o[6] && o[5]) r[1] = d[1];                          // R6
    if (o[6] && o[4]) r[0] = d[0];                          // R6
    return r;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic check_modes(input logic [6:0] s);
    logic [3:0] exp, act;
    exp = {s[3] & s[6], s[2] & s[6], s[1] & s[6], s[0] & s[6]};
    act = {everify_active, pverify_active, erase_active, program_active};
    check8("R9", {4'h0, act}, {4'h0, exp});
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic standby_pulse(input bit hw);
    @(negedge clk);
    if (hw) hw_standby = 1'b1; else sw_standby = 1'b1;
    @(negedge clk);
    hw_standby = 1'b0;
    sw_standby = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [6:0] base [5];
    base[0] = 7'h00; base[1] = 7'h40; base[2] = 7'h60;
    base[3] = 7'h50; base[4] = 7'h4C;

    // R2: reset value with the pin high
    repeat (3) @(negedge clk);
    check8("R2", rd_data, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R2", rd_data, 8'h80);
    check_modes(7'h00);

    // R1: bit 7 ignores written data
    wr(8'h00);
    check8("R1", rd_data, 8'h80);

    // Sweep: every data value from each base state (R4, R5, R6, R7, R9)
    for (int b = 0; b < 5; b++) begin
      for (int d = 0; d < 256; d++) begin
        logic [6:0] exp;
        standby_pulse(d[0]);
        if (base[b] != 7'h00) wr(8'h40);
        if (base[b] != 7'h00 && base[b] != 7'h40) wr({1'b0, base[b]});
        if (d == 0) check8("R1", rd_data, {1'b1, base[b]});
        exp = model_next(base[b], d[7:0]);
        wr(d[7:0]);
        if (base[b] == 7'h00)      check8("R4", rd_data, {1'b1, exp});
        else if (base[b] == 7'h40) check8("R5", rd_data, {1'b1, exp});
        else if (base[b] == 7'h60) check8("R6", rd_data, {1'b1, exp});
        else if (base[b] == 7'h50) check8("R7", rd_data, {1'b1, exp});
        else                       check8("R5", rd_data, {1'b1, exp});
        check_modes(exp);
      end
    end

    // R7: explicit clash case from cleared-but-enabled state
    standby_pulse(1'b0);
    wr(8'h40);
    wr(8'h70);
    check8("R7", rd_data, 8'hC0);

    // Full program entry sequence
    standby_pulse(1'b0);
    wr(8'h40); wr(8'h50); wr(8'h51);
    check8("R6", rd_data, 8'hD1);
    check8("R9", {7'h0, program_active}, 8'h01);

    // R8: pin low clears between edges, stays clear after pin returns
    @(negedge clk);
    #(CLK_PERIOD/4) wp_pin = 1'b0;
    #1 check8("R8", rd_data, 8'h00);
    check8("R9", {7'h0, program_active}, 8'h00);
    wr(8'h40);
    check8("R8", rd_data, 8'h00);
    @(negedge clk);
    wp_pin = 1'b1;
    @(negedge clk);
    check8("R8", rd_data, 8'h80);

    // R2: hardware standby clears
    wr(8'h40); wr(8'h60); wr(8'h62);
    check8("R6", rd_data, 8'hE2);
    standby_pulse(1'b1);
    check8("R2", rd_data, 8'h80);

    // R3: flash disabled reads zero and ignores writes
    @(negedge clk);
    flash_en = 1'b0;
    #1 check8("R3", rd_data, 8'h00);
    wr(8'h40);
    check8("R3", rd_data, 8'h00);
    @(negedge clk);
    flash_en = 1'b1;
    #1 check8("R3", rd_data, 8'h80);

    // R2: reset with the pin low reads 0x00
    @(negedge clk);
    wp_pin = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    check8("R2", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R2", rd_data, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule